// File: doc/BRIEF.md
# Ventilation Fan Start Interlock

This block decides whether a ventilation fan runs, and it raises an alarm when airflow is too low. An operator works a three-position spring-return hand switch. Its positions reach the block as three separate bits: stop, auto and start. A safety request can also start the fan automatically, but only when the switch rests in auto and the request has stayed present for a qualifying time. That time is measured in pulses of a tick enable, so the delay in wall-clock time is the tick period multiplied by a parameter.

Once the fan is running, a retentive run memory keeps it running until the stop position is selected. Removing the safety request does not stop it. The low-flow alarm has two sources. The first is this fan's own airflow sensor, which is only heeded after an arming delay that begins when the fan starts. The second is a low-flow status bit from a companion fan, which is passed through at any time.

Top module: `fan_interlock_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, with no stimulus applied, fan_run and low_flow_alarm are 0. Reset also clears both timers.
- R2: With sw_stop low, a cycle with sw_start high sets fan_run from the next clock edge onward.
- R3: Once fan_run is 1, it stays 1 in every cycle where sw_stop is low. This holds whatever safety_req does, including when safety_req falls.
- R4: The safety qualifier counts tick_en pulses while safety_req is held continuously high. It becomes qualified only after QUAL_TICKS pulses. A low cycle on safety_req returns the count to zero, so a request shorter than that starts nothing.
- R5: A cycle with sw_auto high while the safety request is qualified sets fan_run on the next edge. Without a qualified request, sw_auto alone never sets it.
- R6: A cycle with sw_stop high clears fan_run on the next edge. This takes priority over sw_start or a qualified auto request in the same cycle.
- R7: If stop is selected while a qualified request is present, the fan restarts one cycle after the switch returns to auto. If the request is absent, the fan stays stopped when the switch returns to auto.
- R8: low_flow_own raises low_flow_alarm only once the fan has run for ARM_TICKS tick_en pulses since it last started.
- R9: low_flow_peer high in a cycle sets low_flow_alarm on the next edge, whether the fan runs or not.
- R10: The arming count is cleared while the fan is stopped and restarts from zero on each new start. With the fan stopped and low_flow_peer low, low_flow_alarm is 0 on the next edge.
- R11: Cycles with tick_en low do not advance the qualifying count or the arming count.
- R12: Both outputs are registered. Each reflects the inputs of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_en | input | 1 | Time-base pulse that advances both timers |
| sw_stop | input | 1 | Hand switch in the stop position |
| sw_auto | input | 1 | Hand switch in the auto (rest) position |
| sw_start | input | 1 | Hand switch in the start position |
| safety_req | input | 1 | Safety request for automatic start |
| low_flow_own | input | 1 | This fan's airflow is below threshold |
| low_flow_peer | input | 1 | The companion fan reports low flow |
| fan_run | output | 1 | Fan run command |
| low_flow_alarm | output | 1 | Low-flow alarm |

## Verification
The bench builds the block with QUAL_TICKS=10 and ARM_TICKS=4. These small values let the qualifying and arming boundaries be reached within a few dozen cycles. A request held one tick short of qualification can therefore be compared directly with one held long enough. One phase gates tick_en off, which shows that time only advances on tick pulses. The stop-then-auto sequences are run both with and without a qualified request, to separate the restart case from the stay-stopped case.

// File: rtl/fan_ctrl_pkg.sv
`timescale 1ns/1ps
package fan_ctrl_pkg;
  // width of a counter that must hold values 0..limit
  function automatic int cnt_width(input int limit);
    return (limit < 1) ? 1 : $clog2(limit + 1);
  endfunction

  typedef struct packed {
    logic stop_p;
    logic auto_p;
    logic start_p;
  } hand_sw_t;
endpackage

// File: rtl/fan_rst_sync.sv
`timescale 1ns/1ps
module fan_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fan_tick_timer.sv
`timescale 1ns/1ps
// Saturating tick counter: runs while hold_i is high, clears when it drops.
module fan_tick_timer
  import fan_ctrl_pkg::*;
#(
  parameter int LIMIT = 600
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic hold_i,
  output logic done_o
);
  localparam int CW = cnt_width(LIMIT);
  localparam logic [CW-1:0] LIM_V = CW'(LIMIT);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_lim;

  assign at_lim = (cnt_q == LIM_V);

  always_comb begin
    cnt_d = cnt_q;
    if (!hold_i)                 cnt_d = '0;
    else if (tick_i && !at_lim)  cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign done_o = hold_i && at_lim;
endmodule

// File: rtl/fan_run_mem.sv
`timescale 1ns/1ps
// Retentive run memory, reset-dominant.
module fan_run_mem
  import fan_ctrl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  hand_sw_t sw_i,
  input  logic     qual_i,
  output logic     run_o
);
  logic run_q, run_d, set_req;

  assign set_req = sw_i.start_p || (sw_i.auto_p && qual_i);

  always_comb begin
    run_d = run_q;
    if (sw_i.stop_p)  run_d = 1'b0;
    else if (set_req) run_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= 1'b0;
    else        run_q <= run_d;
  end

  assign run_o = run_q;
endmodule

// File: rtl/fan_interlock_ctrl.sv
`timescale 1ns/1ps
module fan_interlock_ctrl
  import fan_ctrl_pkg::*;
#(
  parameter int QUAL_TICKS = 600,
  parameter int ARM_TICKS  = 45
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_en,
  input  logic sw_stop,
  input  logic sw_auto,
  input  logic sw_start,
  input  logic safety_req,
  input  logic low_flow_own,
  input  logic low_flow_peer,
  output logic fan_run,
  output logic low_flow_alarm
);
  logic     rst_sync_n;
  logic     qual_ok;
  logic     armed;
  logic     run_int;
  logic     alarm_q, alarm_d;
  hand_sw_t sw;

  assign sw = '{stop_p: sw_stop, auto_p: sw_auto, start_p: sw_start};

  fan_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fan_tick_timer #(.LIMIT(QUAL_TICKS)) u_qual (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_i (tick_en),
    .hold_i (safety_req),
    .done_o (qual_ok)
  );

  fan_run_mem u_mem (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .sw_i   (sw),
    .qual_i (qual_ok),
    .run_o  (run_int)
  );

  fan_tick_timer #(.LIMIT(ARM_TICKS)) u_arm (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .tick_i (tick_en),
    .hold_i (run_int),
    .done_o (armed)
  );

  always_comb begin
    alarm_d = (armed && low_flow_own) || low_flow_peer;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) alarm_q <= 1'b0;
    else             alarm_q <= alarm_d;
  end

  assign fan_run        = run_int;
  assign low_flow_alarm = alarm_q;
endmodule

// File: rtl/fan_interlock_ctrl_chk.sv
`timescale 1ns/1ps
module fan_interlock_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic sw_stop,
  input logic sw_start,
  input logic safety_req,
  input logic low_flow_peer,
  input logic fan_run,
  input logic low_flow_alarm
);
  // R2
  start_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_start && !sw_stop) |=> fan_run);

  // R3
  run_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fan_run && !sw_stop) |=> fan_run);

  // R6
  stop_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sw_stop |=> !fan_run);

  // R5
  no_auto_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!safety_req && !sw_start && !fan_run) |=> !fan_run);

  // R9
  peer_alarm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    low_flow_peer |=> low_flow_alarm);

  // R10
  quiet_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!fan_run && !low_flow_peer) |=> !low_flow_alarm);
endmodule

bind fan_interlock_ctrl fan_interlock_ctrl_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_sync_n),
  .sw_stop        (sw_stop),
  .sw_start       (sw_start),
  .safety_req     (safety_req),
  .low_flow_peer  (low_flow_peer),
  .fan_run        (fan_run),
  .low_flow_alarm (low_flow_alarm)
);

// File: tb/fan_interlock_ctrl_test.sv
`timescale 1ns/1ps
module fan_interlock_ctrl_test;
  localparam int QT = 10;
  localparam int AT = 4;

  logic clk = 1'b0;
  logic rst_n, tick_en, sw_stop, sw_auto, sw_start;
  logic safety_req, low_flow_own, low_flow_peer;
  logic fan_run, low_flow_alarm;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  typedef struct {
    bit    run;
    bit    alm;
    string tag;
  } exp_t;
  exp_t sb[$];

  // reference state, derived from the requirements
  int m_sc, m_ac;
  bit m_run;

  always #10 clk = ~clk;

  fan_interlock_ctrl #(.QUAL_TICKS(QT), .ARM_TICKS(AT)) uut (
    .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
    .sw_stop(sw_stop), .sw_auto(sw_auto), .sw_start(sw_start),
    .safety_req(safety_req), .low_flow_own(low_flow_own),
    .low_flow_peer(low_flow_peer),
    .fan_run(fan_run), .low_flow_alarm(low_flow_alarm)
  );

  task automatic check(input bit got, input bit want, input string tag, input string what);
    total++;
    if (got !== want) begin
      bad++;
      $display("FAIL %s %s: actual=%0b expected=%0b at %0t", tag, what, got, want, $time);
    end
  endtask

  // driver: apply one cycle of inputs and push the expected outputs
  task automatic step(input bit s, input bit a, input bit st, input bit sf,
                      input bit own, input bit peer, input bit tk, input string tag);
    exp_t e;
    bit qual;
    @(negedge clk);
    sw_stop = s; sw_auto = a; sw_start = st; safety_req = sf;
    low_flow_own = own; low_flow_peer = peer; tick_en = tk;
    qual  = sf && (m_sc == QT);
    e.alm = (m_run && (m_ac == AT) && own) || peer;
    m_ac  = !m_run ? 0 : ((tk && m_ac < AT) ? m_ac + 1 : m_ac);
    m_sc  = !sf ? 0 : ((tk && m_sc < QT) ? m_sc + 1 : m_sc);
    if (s) m_run = 0;
    else if (st || (a && qual)) m_run = 1;
    e.run = m_run;
    e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic steps(input int n, input bit s, input bit a, input bit st, input bit sf,
                       input bit own, input bit peer, input bit tk, input string tag);
    for (int i = 0; i < n; i++) step(s, a, st, sf, own, peer, tk, tag);
  endtask

  // monitor: compare away from the active edge
  always @(posedge clk) begin
    #5;
    if (sb.size() > 0) begin
      exp_t e;
      e = sb.pop_front();
      check(fan_run, e.run, e.tag, "fan_run");
      check(low_flow_alarm, e.alm, e.tag, "low_flow_alarm");
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    m_sc = 0; m_ac = 0; m_run = 0;
    rst_n = 1'b0; tick_en = 0; sw_stop = 0; sw_auto = 1; sw_start = 0;
    safety_req = 0; low_flow_own = 0; low_flow_peer = 0;
    repeat (3) @(negedge clk);
    check(fan_run, 1'b0, "R1", "fan_run in reset");
    check(low_flow_alarm, 1'b0, "R1", "alarm in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 idle after release
    steps(3, 0, 1, 0, 0, 0, 0, 1, "R1");
    // R4 short request: QT-1 ticks then dropped
    steps(QT - 1, 0, 1, 0, 1, 0, 0, 1, "R4");
    steps(2, 0, 1, 0, 0, 0, 0, 1, "R4");
    // R11 no ticks: request held long, no start
    steps(3 * QT, 0, 1, 0, 1, 0, 0, 0, "R11");
    // R5 qualified auto start
    steps(QT + 3, 0, 1, 0, 1, 0, 0, 1, "R5");
    // R3 run held after request removed
    steps(5, 0, 1, 0, 0, 0, 0, 1, "R3");
    // R7 stop with request present, then return to auto
    steps(QT + 1, 0, 1, 0, 1, 0, 0, 1, "R7");
    steps(2, 1, 0, 0, 1, 0, 0, 1, "R7");
    steps(3, 0, 1, 0, 1, 0, 0, 1, "R7");
    // R7 stop without request: stays stopped
    steps(2, 1, 0, 0, 0, 0, 0, 1, "R7");
    steps(4, 0, 1, 0, 0, 0, 0, 1, "R7");
    // R2 manual start
    steps(1, 0, 0, 1, 0, 0, 0, 1, "R2");
    // R8 own low flow before and after arming
    steps(AT + 4, 0, 1, 0, 0, 1, 0, 1, "R8");
    // R12 alarm drops one cycle after own clears
    steps(2, 0, 1, 0, 0, 0, 0, 1, "R12");
    // R6 stop beats start in the same cycle
    steps(2, 1, 0, 1, 0, 1, 0, 1, "R6");
    // R10 restart re-arms from zero; ticks only every third cycle (R11)
    steps(1, 0, 0, 1, 0, 1, 0, 1, "R10");
    for (int k = 0; k < 6; k++) begin
      steps(2, 0, 1, 0, 0, 1, 0, 0, "R11");
      steps(1, 0, 1, 0, 0, 1, 0, 1, "R10");
    end
    // R9 peer alarm while stopped
    steps(1, 1, 0, 0, 0, 0, 1, 1, "R9");
    steps(3, 0, 1, 0, 0, 0, 1, 1, "R9");
    steps(2, 0, 1, 0, 0, 1, 0, 1, "R10");
    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule